// File: doc/BRIEF.md
# Slot-Table Memory Arbiter

This block shares one memory port among fourteen clients by time division. It has two independent regions, one for external memory and one for internal memory. Each region walks a 64-entry ownership table, one entry per arbitration cycle. Each entry names the client that owns that cycle. When the owner is requesting, it gets the grant. When the owner is idle, the grant falls back to the lowest-numbered client that is requesting. A client that owns no entries is therefore still served whenever owned cycles go unclaimed.

A client can own any number of entries, so bandwidth is shared out by how many entries name each client. Outside logic writes one entry at a time, using a region select, an entry index and a client number. After reset, every table holds a default pattern that gives every client some ownership. The grant for each region is registered, one-hot, and comes with a valid flag.

Top module: `slot_arbiter`

## Requirements
- R1: While reset is high and on the first cycle after it, both grants are all-zero with valid low. The pointer starts at entry 0, and entry i of each table holds client i mod 14.
- R2: If the client named by the current entry is requesting, the grant one cycle later is that client alone.
- R3: If the owner of the current entry is idle and other clients request, the grant goes to the lowest-numbered requesting client.
- R4: If no client of a region requests, that region's next grant is zero and its valid flag is low.
- R5: Each region's pointer advances by one entry on every cycle after reset and wraps from entry 63 to entry 0.
- R6: A table write changes only the addressed entry. Arbitration in the cycle of the write still uses the old content, and the new owner applies from the next cycle on.
- R7: A write addressed to one region leaves the other region's table unchanged. Region select 0 is external and 1 is internal.
- R8: A write whose client value is 14 or 15 is dropped, and the entry keeps its previous owner.
- R9: Each grant vector has at most one bit set, and valid is high exactly when a bit is set.
- R10: A granted client was requesting in the cycle the decision was made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tbl_wr_en | input | 1 | Write one table entry this cycle |
| tbl_wr_region | input | 1 | Target table: 0 external, 1 internal |
| tbl_wr_slot | input | 6 | Entry index to write |
| tbl_wr_client | input | 4 | Client number to store (values above 13 are dropped) |
| ext_req | input | 14 | Per-client requests, external region |
| int_req | input | 14 | Per-client requests, internal region |
| ext_gnt | output | 14 | One-hot grant, external region |
| ext_gnt_vld | output | 1 | External grant is valid |
| int_gnt | output | 14 | One-hot grant, internal region |
| int_gnt_vld | output | 1 | Internal grant is valid |

## Verification
A grant reflects the requests and the table entry that are present before the clock edge, and it appears one edge later. The bench therefore drives the requests and the write on a falling edge and reads the grants on the next falling edge. It predicts each grant from its own copy of the tables and of the pointer. That copy is updated with any write only after the grant for that edge has been predicted, which tests the one-cycle delay before a write takes effect. Reset is checked while it is held, and then across a full wrap of 64 entries with every client requesting.

// File: rtl/slotarb_pkg.sv
package slotarb_pkg;
  localparam int DEF_CLIENTS = 14;
  localparam int DEF_SLOTS   = 64;
  localparam int DEF_REGIONS = 2;

  typedef enum logic {
    MEM_EXT = 1'b0,
    MEM_INT = 1'b1
  } mem_region_e;
endpackage

// File: rtl/slot_table.sv
module slot_table #(
  parameter int NUM_SLOTS   = slotarb_pkg::DEF_SLOTS,
  parameter int NUM_CLIENTS = slotarb_pkg::DEF_CLIENTS,
  parameter int PTR_W       = $clog2(NUM_SLOTS),
  parameter int IDX_W       = $clog2(NUM_CLIENTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_slot,
  input  logic [IDX_W-1:0] wr_client,
  input  logic [PTR_W-1:0] rd_slot,
  output logic [IDX_W-1:0] rd_client
);
  localparam logic [IDX_W-1:0] LAST_CLI = IDX_W'(NUM_CLIENTS - 1);

  logic [IDX_W-1:0] owner_mem [NUM_SLOTS];
  logic             wr_ok;

  assign wr_ok = wr_en && (wr_client <= LAST_CLI);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SLOTS; i++)
        owner_mem[i] <= IDX_W'(i % NUM_CLIENTS);
    end else if (wr_ok) begin
      owner_mem[wr_slot] <= wr_client;
    end
  end

  assign rd_client = owner_mem[rd_slot];

  always_comb begin
    AST_OWNER_RANGE: assert (rst !== 1'b0 || rd_client <= LAST_CLI); // R8
  end
endmodule

// File: rtl/slot_picker.sv
module slot_picker #(
  parameter int NUM_CLIENTS = slotarb_pkg::DEF_CLIENTS,
  parameter int IDX_W       = $clog2(NUM_CLIENTS)
) (
  input  logic [NUM_CLIENTS-1:0] req,
  input  logic [IDX_W-1:0]       owner,
  output logic [NUM_CLIENTS-1:0] pick,
  output logic                   owner_req
);
  logic [NUM_CLIENTS-1:0] owner_hot;
  logic [NUM_CLIENTS-1:0] lowest_hot;
  logic                   found;

  always_comb begin
    owner_hot = '0;
    for (int c = 0; c < NUM_CLIENTS; c++)
      if (owner == IDX_W'(c)) owner_hot[c] = 1'b1;
  end

  assign owner_req = |(owner_hot & req);

  always_comb begin
    lowest_hot = '0;
    found      = 1'b0;
    for (int c = 0; c < NUM_CLIENTS; c++) begin
      if (req[c] && !found) begin
        lowest_hot[c] = 1'b1;
        found         = 1'b1;
      end
    end
  end

  assign pick = owner_req ? owner_hot : lowest_hot;
endmodule

// File: rtl/arb_region.sv
module arb_region #(
  parameter int NUM_SLOTS   = slotarb_pkg::DEF_SLOTS,
  parameter int NUM_CLIENTS = slotarb_pkg::DEF_CLIENTS,
  parameter int PTR_W       = $clog2(NUM_SLOTS),
  parameter int IDX_W       = $clog2(NUM_CLIENTS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [PTR_W-1:0]       wr_slot,
  input  logic [IDX_W-1:0]       wr_client,
  input  logic [NUM_CLIENTS-1:0] req,
  output logic [NUM_CLIENTS-1:0] gnt,
  output logic                   gnt_vld
);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(NUM_SLOTS - 1);

  logic [PTR_W-1:0]       slot_ptr;
  logic [IDX_W-1:0]       owner;
  logic [NUM_CLIENTS-1:0] pick;
  logic                   owner_req;
  logic                   live_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_ptr <= '0;
      live_q   <= 1'b0;
    end else begin
      slot_ptr <= (slot_ptr == LAST_SLOT) ? '0 : slot_ptr + 1'b1;
      live_q   <= 1'b1;
    end
  end

  slot_table #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_CLIENTS(NUM_CLIENTS), .PTR_W(PTR_W), .IDX_W(IDX_W)
  ) table_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_client(wr_client), .rd_slot(slot_ptr), .rd_client(owner)
  );

  slot_picker #(
    .NUM_CLIENTS(NUM_CLIENTS), .IDX_W(IDX_W)
  ) picker_i (
    .req(req), .owner(owner), .pick(pick), .owner_req(owner_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt     <= '0;
      gnt_vld <= 1'b0;
    end else begin
      gnt     <= pick;
      gnt_vld <= |req;
    end
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (slot_ptr != LAST_SLOT) |=> (slot_ptr == $past(slot_ptr) + 1'b1)); // R5
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (slot_ptr == LAST_SLOT) |=> (slot_ptr == '0)); // R5
  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt) && (gnt_vld == (gnt != '0))); // R9
  AST_GNT_REQ: assert property (@(posedge clk) disable iff (rst || !live_q)
    ((gnt & ~$past(req)) == '0)); // R10
  AST_IDLE: assert property (@(posedge clk) disable iff (rst || !live_q)
    ($past(req) == '0) |-> !gnt_vld); // R4
  AST_OWNER_WINS: assert property (@(posedge clk) disable iff (rst || !live_q)
    $past(owner_req) |-> ($countones(gnt) == 1 && gnt[$past(owner)])); // R2
endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter #(
  parameter int NUM_SLOTS   = slotarb_pkg::DEF_SLOTS,
  parameter int NUM_CLIENTS = slotarb_pkg::DEF_CLIENTS,
  parameter int PTR_W       = $clog2(NUM_SLOTS),
  parameter int IDX_W       = $clog2(NUM_CLIENTS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tbl_wr_en,
  input  logic                   tbl_wr_region,
  input  logic [PTR_W-1:0]       tbl_wr_slot,
  input  logic [IDX_W-1:0]       tbl_wr_client,
  input  logic [NUM_CLIENTS-1:0] ext_req,
  input  logic [NUM_CLIENTS-1:0] int_req,
  output logic [NUM_CLIENTS-1:0] ext_gnt,
  output logic                   ext_gnt_vld,
  output logic [NUM_CLIENTS-1:0] int_gnt,
  output logic                   int_gnt_vld
);
  import slotarb_pkg::*;

  localparam int NREG = DEF_REGIONS;

  logic [NUM_CLIENTS-1:0] req_r [NREG];
  logic [NUM_CLIENTS-1:0] gnt_r [NREG];
  logic                   vld_r [NREG];

  assign req_r[MEM_EXT] = ext_req;
  assign req_r[MEM_INT] = int_req;

  for (genvar r = 0; r < NREG; r++) begin : g_region
    logic sel;
    assign sel = tbl_wr_en && (tbl_wr_region == 1'(r));

    arb_region #(
      .NUM_SLOTS(NUM_SLOTS), .NUM_CLIENTS(NUM_CLIENTS), .PTR_W(PTR_W), .IDX_W(IDX_W)
    ) region_i (
      .clk(clk), .rst(rst), .wr_en(sel), .wr_slot(tbl_wr_slot),
      .wr_client(tbl_wr_client), .req(req_r[r]), .gnt(gnt_r[r]), .gnt_vld(vld_r[r])
    );
  end

  assign ext_gnt     = gnt_r[MEM_EXT];
  assign ext_gnt_vld = vld_r[MEM_EXT];
  assign int_gnt     = gnt_r[MEM_INT];
  assign int_gnt_vld = vld_r[MEM_INT];
endmodule

// File: tb/slot_arbiter_tb_top.sv
`timescale 1ns/1ps
module slot_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we = 1'b0;
  logic        wrg = 1'b0;
  logic [5:0]  wsl = '0;
  logic [3:0]  wcl = '0;
  logic [13:0] ereq = '0, ireq = '0;
  logic [13:0] egnt, ignt;
  logic        evld, ivld;

  int n_chk = 0;
  int n_bad = 0;
  int mtab [2][64];
  int mptr = 0;

  always #10 clk = ~clk;

  slot_arbiter dut_i (
    .clk(clk), .rst(rst), .tbl_wr_en(we), .tbl_wr_region(wrg),
    .tbl_wr_slot(wsl), .tbl_wr_client(wcl), .ext_req(ereq), .int_req(ireq),
    .ext_gnt(egnt), .ext_gnt_vld(evld), .int_gnt(ignt), .int_gnt_vld(ivld)
  );

  function automatic logic [13:0] expect_gnt(input int rg, input logic [13:0] rq);
    int own;
    own = mtab[rg][mptr];
    if (rq[own]) return 14'(1) << own;
    for (int c = 0; c < 14; c++) if (rq[c]) return 14'(1) << c;
    return '0;
  endfunction

  task automatic check(input string tag, input logic [13:0] act, input logic [13:0] exp_v,
                       input logic av, input logic ev);
    n_chk++;
    if (act !== exp_v || av !== ev) begin
      n_bad++;
      $display("FAIL %s: got gnt=%h vld=%b, expected gnt=%h vld=%b", tag, act, av, exp_v, ev);
    end
  endtask

  // one arbitration cycle; inputs are driven on the falling edge, grants read on the next
  task automatic cyc(input string tag, input logic [13:0] er, input logic [13:0] ir,
                     input logic w = 1'b0, input logic r = 1'b0,
                     input int s = 0, input int c = 0);
    logic [13:0] xe, xi;
    ereq = er; ireq = ir; we = w; wrg = r; wsl = 6'(s); wcl = 4'(c);
    xe = expect_gnt(0, er);
    xi = expect_gnt(1, ir);
    @(negedge clk);
    check({tag, " ext"}, egnt, xe, evld, xe != 0);
    check({tag, " int"}, ignt, xi, ivld, xi != 0);
    if (w && c < 14) mtab[r][s] = c;
    mptr = (mptr + 1) % 64;
    we = 1'b0;
  endtask

  task automatic t_reset;
    ereq = '1; ireq = '1;
    repeat (3) @(negedge clk);
    check("R1 reset ext", egnt, '0, evld, 1'b0);
    check("R1 reset int", ignt, '0, ivld, 1'b0);
    rst = 1'b0;
    mptr = 0;
  endtask

  task automatic t_default_sweep; // R1 R2 R5 R9: full wrap plus a few
    for (int k = 0; k < 70; k++) cyc("R1 R2 R5 R9 default table", '1, '1);
  endtask

  task automatic t_fallback; // R3 R10
    for (int k = 0; k < 20; k++)
      cyc("R3 R10 fallback", 14'b00_0010_0000_1000, 14'b10_0000_0000_0000);
  endtask

  task automatic t_idle; // R4
    for (int k = 0; k < 4; k++) cyc("R4 idle", '0, 14'(1) << k);
  endtask

  task automatic t_write; // R6 R7
    int nxt;
    nxt = (mptr + 1) % 64;
    cyc("R6 write next", '1, '1, 1'b1, 1'b0, nxt, 13);
    cyc("R6 R7 new owner ext only", '1, '1);
    cyc("R6 write current slot", '1, '1, 1'b1, 1'b1, mptr, 12);
    for (int k = 0; k < 64; k++) cyc("R6 R7 sweep after writes", '1, '1);
  endtask

  task automatic t_bad_write; // R8
    int nxt;
    nxt = (mptr + 1) % 64;
    cyc("R8 drop write", '1, '1, 1'b1, 1'b0, nxt, 15);
    cyc("R8 owner kept", '1, '1);
    nxt = (mptr + 1) % 64;
    cyc("R8 drop write 14", '1, '1, 1'b1, 1'b1, nxt, 14);
    cyc("R8 owner kept int", '1, '1);
  endtask

  initial begin
    for (int r = 0; r < 2; r++)
      for (int s = 0; s < 64; s++) mtab[r][s] = s % 14;
    @(negedge clk);
    t_reset();
    t_default_sweep();
    t_fallback();
    t_idle();
    t_write();
    t_bad_write();
    t_fallback();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule